// File: doc/BRIEF.md
# Eight-Point Radix-2 Fourier Transform Engine

This block computes the forward discrete Fourier transform of a frame of eight complex fixed-point samples. It uses three radix-2 decimation-in-time butterfly stages. A whole frame arrives in parallel on one cycle, marked by a valid strobe. After a fixed pipeline delay, all eight frequency bins leave in parallel with their own valid strobe. A new frame may enter on every clock.

There are no general-purpose multipliers and no coefficient table.
- The unit twiddles (1 and -j) reduce to sign changes and to exchanging the real and imaginary parts.
- The two diagonal twiddles need a scale by 1/sqrt(2). A fixed shift-and-add network applies it, using the value 181/256 with round-to-nearest.
- Each stage widens the word by one bit, so 16-bit inputs give 19-bit results.

Samples must be placed at the input in bit-reversed slot order. The bins then come out in natural order.

Top module: `fft8_dit`

## Requirements
- R1: Input slot k (bits [16k+15:16k] of the real and imaginary buses) carries time sample bitrev3(k), i.e. samples 0,4,2,6,1,5,3,7 in slots 0..7. Output slot k (bits [19k+18:19k]) carries bin k of X[k] = sum x[n]·e^(-j2πkn/8). For input components within ±2048, every bin component lies within ±4 LSB of the exact transform of the quantized inputs.
- R2: Bins reached only through the unit twiddles are bit-exact even at full 16-bit scale, with no wrap in the 19-bit result. This covers a constant frame at -32768 or +32767, and an alternating ±32767 frame.
- R3: When the valid input is high in cycle n, the valid output is high in cycle n+3 and carries that frame's result. Exactly one output cycle is produced per accepted frame.
- R4: Frames presented on consecutive cycles are all accepted and emerge on consecutive cycles, in order.
- R5: While no result is being delivered, the output buses hold the last delivered frame unchanged.
- R6: A synchronous active-high reset drops the valid output, clears the output buses to zero and discards any frame in flight.
- R7: Bin 0 equals the exact sum of the eight input samples for any input, real and imaginary parts separately.
- R8: The sign convention is that of the forward transform. An impulse of value A at sample 2 yields bins A, -jA, -A, jA, A, -jA, -A, jA exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Frame on the input buses is valid this cycle |
| inRe | input | 128 | Real parts, eight signed 16-bit samples in bit-reversed slot order |
| inIm | input | 128 | Imaginary parts, same layout as inRe |
| outValid | output | 1 | Result frame valid this cycle |
| outRe | output | 152 | Real parts, eight signed 19-bit bins in natural order |
| outIm | output | 152 | Imaginary parts, same layout as outRe |

## Verification
The hardest situation to reach from the ports is the one where the word-growth budget is used to its last bit. This needs full-scale frames whose energy concentrates into a single bin; the stimulus reaches it with constant and alternating full-scale frames, where every path is exact and any lost bit shows as a wrong sign. The diagonal-twiddle paths only matter when energy sits on the odd bins. They are driven with impulses at odd sample positions and quantized tones at bin 3, compared with a tolerance. A reset is also raised while a frame is still inside the pipeline, to show that it never emerges.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  // transform size and number of radix-2 stages
  localparam int NPT  = 8;
  localparam int NSTG = 3;

  // per-stage load strobes from control to datapath
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageStb_t;
endpackage

// File: rtl/fft8_ctrl.sv
module fft8_ctrl
  import fft8_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output stageStb_t stb,
  output logic      outValid
);
  logic [NSTG-1:0] vPipe;

  always_ff @(posedge clk) begin
    if (rst) vPipe <= '0;
    else     vPipe <= {vPipe[NSTG-2:0], inValid};
  end

  assign stb.ld1  = inValid;
  assign stb.ld2  = vPipe[0];
  assign stb.ld3  = vPipe[1];
  assign outValid = vPipe[NSTG-1];

  // cycles since reset, saturating, used only to bound the look-back below
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);
endmodule

// File: rtl/fft8_twiddle.sv
module fft8_twiddle #(
  parameter int IW = 16,
  parameter int K  = 0
) (
  input  logic signed [IW-1:0] aRe,
  input  logic signed [IW-1:0] aIm,
  output logic signed [IW:0]   tRe,
  output logic signed [IW:0]   tIm
);
  localparam int PW = IW + 9;
  localparam logic signed [PW-1:0] RND = PW'(128);

  // scale by 181/256 (about 1/sqrt(2)) with shifts and adds, rounded
  function automatic logic signed [IW:0] mulRt2(input logic signed [IW:0] v);
    logic signed [PW-1:0] w;
    logic signed [PW-1:0] p;
    w = PW'(v);
    p = (w <<< 7) + (w <<< 5) + (w <<< 4) + (w <<< 2) + w;
    return (IW+1)'((p + RND) >>> 8);
  endfunction

  logic signed [IW:0] eRe, eIm;
  assign eRe = (IW+1)'(aRe);
  assign eIm = (IW+1)'(aIm);

  generate
    if (K == 0) begin : g_unit
      assign tRe = eRe;
      assign tIm = eIm;
    end else if (K == 2) begin : g_negj
      assign tRe = eIm;
      assign tIm = -eRe;
    end else begin : g_diag
      logic signed [IW:0] sumV, difV;
      assign sumV = eRe + eIm;
      assign difV = eIm - eRe;
      if (K == 1) begin : g_k1
        assign tRe = mulRt2(sumV);
        assign tIm = mulRt2(difV);
      end else begin : g_k3
        assign tRe = mulRt2(difV);
        assign tIm = -mulRt2(sumV);
      end
    end
  endgenerate
endmodule

// File: rtl/fft8_datapath.sv
module fft8_datapath
  import fft8_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  stageStb_t                  stb,
  input  logic [NPT*W-1:0]           inRe,
  input  logic [NPT*W-1:0]           inIm,
  output logic [NPT*(W+NSTG)-1:0]    outRe,
  output logic [NPT*(W+NSTG)-1:0]    outIm
);
  localparam int WO = W + NSTG;

  logic signed [W-1:0]  xRe [NPT];
  logic signed [W-1:0]  xIm [NPT];
  logic signed [WO-1:0] stRe [1:NSTG][NPT];
  logic signed [WO-1:0] stIm [1:NSTG][NPT];
  logic signed [WO-1:0] nxRe [1:NSTG][NPT];
  logic signed [WO-1:0] nxIm [1:NSTG][NPT];
  logic [NSTG:1] ldVec;

  assign ldVec = {stb.ld3, stb.ld2, stb.ld1};

  genvar i, s, b;
  generate
    for (i = 0; i < NPT; i++) begin : g_io
      assign xRe[i] = inRe[i*W +: W];
      assign xIm[i] = inIm[i*W +: W];
      assign outRe[i*WO +: WO] = stRe[NSTG][i];
      assign outIm[i*WO +: WO] = stIm[NSTG][i];
    end

    for (s = 1; s <= NSTG; s++) begin : g_stage
      localparam int SPAN = 1 << (s - 1);
      localparam int IW   = W + s - 1;
      for (b = 0; b < NPT/2; b++) begin : g_bfly
        localparam int GRP = b / SPAN;
        localparam int J   = b % SPAN;
        localparam int TOP = GRP * 2 * SPAN + J;
        localparam int BOT = TOP + SPAN;
        localparam int K   = J * (NPT / (2 * SPAN));

        logic signed [IW-1:0] pRe, pIm, qRe, qIm;
        logic signed [IW:0]   tRe, tIm, eRe, eIm;
        logic signed [IW:0]   sRe, sIm, dRe, dIm;

        if (s == 1) begin : g_src0
          assign pRe = xRe[TOP];
          assign pIm = xIm[TOP];
          assign qRe = xRe[BOT];
          assign qIm = xIm[BOT];
        end else begin : g_srcN
          assign pRe = IW'(stRe[s-1][TOP]);
          assign pIm = IW'(stIm[s-1][TOP]);
          assign qRe = IW'(stRe[s-1][BOT]);
          assign qIm = IW'(stIm[s-1][BOT]);
        end

        fft8_twiddle #(.IW(IW), .K(K)) i_twd (
          .aRe(qRe), .aIm(qIm), .tRe(tRe), .tIm(tIm)
        );

        assign eRe = (IW+1)'(pRe);
        assign eIm = (IW+1)'(pIm);
        assign sRe = eRe + tRe;
        assign sIm = eIm + tIm;
        assign dRe = eRe - tRe;
        assign dIm = eIm - tIm;

        assign nxRe[s][TOP] = WO'(sRe);
        assign nxIm[s][TOP] = WO'(sIm);
        assign nxRe[s][BOT] = WO'(dRe);
        assign nxIm[s][BOT] = WO'(dIm);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int st = 1; st <= NSTG; st++)
        for (int n = 0; n < NPT; n++) begin
          stRe[st][n] <= '0;
          stIm[st][n] <= '0;
        end
    end else begin
      for (int st = 1; st <= NSTG; st++)
        if (ldVec[st])
          for (int n = 0; n < NPT; n++) begin
            stRe[st][n] <= nxRe[st][n];
            stIm[st][n] <= nxIm[st][n];
          end
    end
  end

  // plain sum of the inputs, independent of the butterfly tree
  logic signed [WO-1:0] inSumRe, inSumIm;
  always_comb begin
    inSumRe = '0;
    inSumIm = '0;
    for (int n = 0; n < NPT; n++) begin
      inSumRe = inSumRe + WO'(xRe[n]);
      inSumIm = inSumIm + WO'(xIm[n]);
    end
  end

  // R5
  hold_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.ld3 |=> ($stable(outRe) && $stable(outIm)));

  // R7
  dc_bin_chk: assert property (@(posedge clk) disable iff (rst)
    stb.ld3 |=> ((stRe[NSTG][0] == $past(inSumRe, 3)) &&
                 (stIm[NSTG][0] == $past(inSumIm, 3))));
endmodule

// File: rtl/fft8_dit.sv
module fft8_dit
  import fft8_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [NPT*W-1:0]        inRe,
  input  logic [NPT*W-1:0]        inIm,
  output logic                    outValid,
  output logic [NPT*(W+NSTG)-1:0] outRe,
  output logic [NPT*(W+NSTG)-1:0] outIm
);
  stageStb_t stb;

  fft8_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .stb(stb), .outValid(outValid)
  );

  fft8_datapath #(.W(W)) i_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .inRe(inRe), .inIm(inIm), .outRe(outRe), .outIm(outIm)
  );
endmodule

// File: tb/test_fft8_dit.sv
module test_fft8_dit;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int WO  = 19;
  localparam int NPT = 8;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [NPT*W-1:0]  inRe = '0;
  logic [NPT*W-1:0]  inIm = '0;
  logic              outValid;
  logic [NPT*WO-1:0] outRe, outIm;

  fft8_dit #(.W(W)) i_fft8_dit (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int tag;                        // 1, 2 or 8: requirement of the frame
    int cyc;                        // cycle count when driven
    logic [2*NPT*32-1:0] vals;      // re bins then im bins
  } expItem_t;

  expItem_t sbQ[$];
  int nChecks = 0, nFails = 0, cyc = 0;
  int framesIn = 0, framesOut = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tagName(int t);
    if (t == 2) return "R2";
    if (t == 8) return "R8";
    return "R1";
  endfunction

  function automatic int bitrev3(int k);
    return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
  endfunction

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic check(bit ok, string req, int act, int exp, string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one frame in one cycle; expected bins go to the scoreboard
  task automatic sendFrame(input int xr[NPT], input int xi[NPT], input int tag, input bit push);
    expItem_t it;
    real re, im, ang;
    it.vals = '0;
    for (int k = 0; k < NPT; k++) begin
      re = 0.0; im = 0.0;
      for (int n = 0; n < NPT; n++) begin
        ang = 2.0 * PI * real'(k * n) / 8.0;
        re += real'(xr[n]) * $cos(ang) + real'(xi[n]) * $sin(ang);
        im += real'(xi[n]) * $cos(ang) - real'(xr[n]) * $sin(ang);
      end
      it.vals[k*32 +: 32]       = rnd(re);
      it.vals[(NPT+k)*32 +: 32] = rnd(im);
    end
    @(negedge clk);
    inValid = 1'b1;
    for (int sl = 0; sl < NPT; sl++) begin
      inRe[sl*W +: W] = W'(xr[bitrev3(sl)]);
      inIm[sl*W +: W] = W'(xi[bitrev3(sl)]);
    end
    it.tag = tag;
    it.cyc = cyc;
    if (push) begin
      sbQ.push_back(it);
      framesIn++;
    end
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: pops and compares as results appear
  logic [NPT*WO-1:0] lastRe, lastIm;
  bit haveLast = 0;
  always @(negedge clk) begin
    if (rst) begin
      haveLast = 0;
    end else if (outValid) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R3", 1, 0, "unexpected outValid");
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        framesOut++;
        check(cyc == it.cyc + 3, "R3", cyc - it.cyc, 3, "latency");
        for (int k = 0; k < NPT; k++) begin
          int aR, aI, eR, eI, tol;
          aR = int'(signed'(outRe[k*WO +: WO]));
          aI = int'(signed'(outIm[k*WO +: WO]));
          eR = int'(signed'(it.vals[k*32 +: 32]));
          eI = int'(signed'(it.vals[(NPT+k)*32 +: 32]));
          if (k == 0) begin
            // R7: bin 0 is exact for every frame
            check(aR == eR, "R7", aR, eR, "bin0 re");
            check(aI == eI, "R7", aI, eI, "bin0 im");
          end else begin
            tol = (it.tag == 1) ? 4 : 0;
            check((aR - eR <= tol) && (eR - aR <= tol), tagName(it.tag), aR, eR,
                  $sformatf("bin%0d re", k));
            check((aI - eI <= tol) && (eI - aI <= tol), tagName(it.tag), aI, eI,
                  $sformatf("bin%0d im", k));
          end
        end
      end
      lastRe = outRe;
      lastIm = outIm;
      haveLast = 1;
    end else if (haveLast) begin
      // R5: held while idle
      check(outRe == lastRe && outIm == lastIm, "R5",
            int'(signed'(outRe[WO-1:0])), int'(signed'(lastRe[WO-1:0])), "hold bin0 re");
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL R3 watchdog: actual %0d cycles expected fewer than %0d", cyc, 50000);
    finishTest();
  end

  initial begin
    int xr[NPT], xi[NPT];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    check(outValid == 1'b0, "R6", int'(outValid), 0, "outValid after reset");
    check(outRe == '0 && outIm == '0, "R6", int'(signed'(outRe[WO-1:0])), 0, "outputs after reset");

    // R8 impulse at n=0 and n=2
    foreach (xr[n]) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 1000;
    sendFrame(xr, xi, 8, 1); idle(4);
    foreach (xr[n]) begin xr[n] = 0; xi[n] = 0; end
    xr[2] = 1500; xi[2] = -700;
    sendFrame(xr, xi, 8, 1); idle(4);

    // R1 impulse at n=1 and a bin-3 tone
    foreach (xr[n]) begin xr[n] = 0; xi[n] = 0; end
    xr[1] = 2000; xi[1] = -1200;
    sendFrame(xr, xi, 1, 1); idle(3);
    foreach (xr[n]) begin
      xr[n] = rnd(1800.0 * $cos(2.0 * PI * 3.0 * real'(n) / 8.0));
      xi[n] = rnd(1800.0 * $sin(2.0 * PI * 3.0 * real'(n) / 8.0));
    end
    sendFrame(xr, xi, 1, 1); idle(3);

    // R2 full-scale constant and alternating frames
    foreach (xr[n]) begin xr[n] = -32768; xi[n] = -32768; end
    sendFrame(xr, xi, 2, 1);
    foreach (xr[n]) begin xr[n] = 32767; xi[n] = 32767; end
    sendFrame(xr, xi, 2, 1);
    foreach (xr[n]) begin
      xr[n] = (n % 2 == 0) ? 32767 : -32767;
      xi[n] = (n % 2 == 0) ? -32768 : 32767;
    end
    sendFrame(xr, xi, 2, 1); idle(3);

    // R4 back-to-back random frames
    for (int f = 0; f < 6; f++) begin
      foreach (xr[n]) begin
        xr[n] = int'($urandom_range(4096)) - 2048;
        xi[n] = int'($urandom_range(4096)) - 2048;
      end
      sendFrame(xr, xi, 1, 1);
    end
    idle(6);
    check(framesOut == framesIn && sbQ.size() == 0, "R4", framesOut, framesIn, "frames delivered");

    // R6 reset while a frame is in flight
    foreach (xr[n]) begin xr[n] = 500; xi[n] = 0; end
    sendFrame(xr, xi, 1, 0);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R6", int'(outValid), 0, "no output after reset");
    end
    check(outRe == '0 && outIm == '0, "R6", int'(signed'(outRe[WO-1:0])), 0, "cleared outputs");

    // R1 random frames with gaps
    for (int f = 0; f < 4; f++) begin
      foreach (xr[n]) begin
        xr[n] = int'($urandom_range(4096)) - 2048;
        xi[n] = int'($urandom_range(4096)) - 2048;
      end
      sendFrame(xr, xi, 1, 1);
      idle(f + 1);
    end
    idle(5);
    check(sbQ.size() == 0, "R3", sbQ.size(), 0, "scoreboard empty at end");
    finishTest();
  end
endmodule